// File: doc/BRIEF.md
# I2C Start/Stop Bus Monitor

This block watches an already synchronized pair of two-wire bus lines (clock and data) and recognises the two framing conditions of the bus: a start, where data falls while the clock is high, and a stop, where data rises while the clock is high. It keeps two status flags, one for each condition. Each flag records only the condition seen most recently. From those two flags it derives a bus-free indication that tells a firmware-driven master when it may claim the bus.

The block also keeps a sticky event flag. This flag is set on every start, on every stop, and whenever a companion shift register pulses its byte-complete strobe. The host clears it through a clear input, and an interrupt output presents the flag gated by an enable. A module-enable input clears the condition flags and suspends all event detection while it is low. The block decodes no addresses, shifts no data and never drives either bus line.

Top module: `bus_cond_watch`

## Requirements
- R1: During and after synchronous reset, s_flag=0, p_flag=0, irq_flag=0, irq=0 and bus_free=1.
- R2: A start (scl_s high on two consecutive samples while sda_s goes from 1 to 0) with mod_en=1 gives s_flag=1 and p_flag=0 one clock edge later.
- R3: A stop (scl_s high on two consecutive samples while sda_s goes from 0 to 1) with mod_en=1 gives p_flag=1 and s_flag=0 one clock edge later. The two flags are never both 1.
- R4: A change of sda_s while scl_s is low is no condition: the flags and irq_flag keep their values.
- R5: bus_free is 1 when p_flag=1 or when both flags are 0, and is 0 while s_flag=1.
- R6: irq_flag is set one edge after a start, a stop or a byte_done pulse, and then stays set until flag_clr=1.
- R7: irq equals irq_flag while irq_en=1 and is 0 while irq_en=0. irq_flag is still set while irq_en=0.
- R8: A repeated start while s_flag=1 keeps s_flag=1 and sets irq_flag again.
- R9: While mod_en=0, s_flag and p_flag read 0 from the next edge on, and neither conditions nor byte_done set any flag. Line history keeps tracking, so enabling on steady lines detects nothing.
- R10: When an event and flag_clr arrive in the same cycle, irq_flag ends up set.
- R11: A clock edge on scl_s while sda_s is steady is no condition and changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_en | input | 1 | Module enable |
| irq_en | input | 1 | Interrupt enable |
| scl_s | input | 1 | Synchronized bus clock line |
| sda_s | input | 1 | Synchronized bus data line |
| byte_done | input | 1 | Byte-complete strobe from the shift register |
| flag_clr | input | 1 | Clears the event flag |
| s_flag | output | 1 | Last condition seen was a start |
| p_flag | output | 1 | Last condition seen was a stop |
| bus_free | output | 1 | Bus may be claimed |
| irq_flag | output | 1 | Sticky event flag |
| irq | output | 1 | Event flag gated by irq_en |

## Verification
Conditions are found by comparing the current line sample with the value held from the previous edge. The flags therefore change on the first rising edge after the line change. bus_free and irq follow the flags combinationally within that same cycle. The bench drives every input at a falling edge, waits for one rising edge, and samples a nanosecond later. Each vector's expectations therefore describe the state one edge after its inputs. Coincident events, such as a clear together with a stop, are placed in single vectors so that the priority shows in that one cycle.

// File: rtl/bus_mon_pkg.sv
package bus_mon_pkg;

    // number of sources feeding the event flag: start, stop, byte done
    localparam int NUM_EVT_SRC = 3;
    localparam int EVT_START   = 0;
    localparam int EVT_STOP    = 1;
    localparam int EVT_BYTE    = 2;

    // idle level of both bus lines
    localparam logic LINE_IDLE = 1'b1;

    typedef struct packed {
        logic start;
        logic stop;
    } cond_t;

    typedef struct packed {
        logic s;
        logic p;
    } cond_state_t;

    function automatic logic bus_is_free(input cond_state_t st);
        return st.p | (~st.s & ~st.p);
    endfunction

endpackage

// File: rtl/line_cond_detect.sv
module line_cond_detect
    import bus_mon_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  scl_i,
    input  logic  sda_i,
    output cond_t cond_o
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= LINE_IDLE;
            sda_q <= LINE_IDLE;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    logic clk_held;
    assign clk_held     = scl_q & scl_i;
    assign cond_o.start = clk_held & sda_q & ~sda_i;
    assign cond_o.stop  = clk_held & ~sda_q & sda_i;

    // a data change with the clock low must never look like a condition
    assert_low_clk_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        !scl_i |-> !cond_o.start && !cond_o.stop);
endmodule

// File: rtl/cond_status.sv
module cond_status
    import bus_mon_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        en_i,
    input  cond_t       cond_i,
    output cond_state_t st_o
);
    cond_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            st_q <= '0;
        end else if (cond_i.start) begin
            st_q <= '{s: 1'b1, p: 1'b0};
        end else if (cond_i.stop) begin
            st_q <= '{s: 1'b0, p: 1'b1};
        end
    end

    assign st_o = st_q;

    assert_start_sets_s_R2: assert property (@(posedge clk) disable iff (rst)
        en_i && cond_i.start |=> st_o.s && !st_o.p);
    assert_stop_sets_p_R3: assert property (@(posedge clk) disable iff (rst)
        en_i && cond_i.stop |=> st_o.p && !st_o.s);
    assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({st_o.s, st_o.p}));
    assert_disable_clears_R9: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> !st_o.s && !st_o.p);
endmodule

// File: rtl/evt_flag.sv
module evt_flag #(
    parameter int NSRC = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en_i,
    input  logic [NSRC-1:0] src_i,
    input  logic            clr_i,
    output logic            flag_o
);
    logic [NSRC-1:0] gated;

    for (genvar g = 0; g < NSRC; g++) begin : g_gate
        assign gated[g] = src_i[g] & en_i;
    end

    logic any_evt;
    assign any_evt = |gated;

    logic flag_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (any_evt) begin
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        flag_o && !clr_i |=> flag_o);
    assert_set_beats_clr_R10: assert property (@(posedge clk) disable iff (rst)
        en_i && (|src_i) |=> flag_o);
    assert_idle_keeps_clear_R9: assert property (@(posedge clk) disable iff (rst)
        !en_i && !flag_o |=> !flag_o);
endmodule

// File: rtl/bus_cond_watch.sv
module bus_cond_watch
    import bus_mon_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic mod_en,
    input  logic irq_en,
    input  logic scl_s,
    input  logic sda_s,
    input  logic byte_done,
    input  logic flag_clr,
    output logic s_flag,
    output logic p_flag,
    output logic bus_free,
    output logic irq_flag,
    output logic irq
);
    cond_t       cond;
    cond_state_t st;
    logic [NUM_EVT_SRC-1:0] evt_src;

    line_cond_detect u_detect (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (scl_s),
        .sda_i  (sda_s),
        .cond_o (cond)
    );

    cond_status u_status (
        .clk    (clk),
        .rst    (rst),
        .en_i   (mod_en),
        .cond_i (cond),
        .st_o   (st)
    );

    always_comb begin
        evt_src            = '0;
        evt_src[EVT_START] = cond.start;
        evt_src[EVT_STOP]  = cond.stop;
        evt_src[EVT_BYTE]  = byte_done;
    end

    evt_flag #(.NSRC(NUM_EVT_SRC)) u_flag (
        .clk    (clk),
        .rst    (rst),
        .en_i   (mod_en),
        .src_i  (evt_src),
        .clr_i  (flag_clr),
        .flag_o (irq_flag)
    );

    assign s_flag   = st.s;
    assign p_flag   = st.p;
    assign bus_free = bus_is_free(st);
    assign irq      = irq_flag & irq_en;

    assert_busy_not_free_R5: assert property (@(posedge clk) disable iff (rst)
        s_flag |-> !bus_free);
    assert_stop_frees_R5: assert property (@(posedge clk) disable iff (rst)
        p_flag |-> bus_free);
    assert_irq_masked_R7: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq);
endmodule

// File: tb/tb_bus_cond_watch.sv
module tb_bus_cond_watch;
    logic clk = 1'b0;
    logic rst, mod_en, irq_en, scl_s, sda_s, byte_done, flag_clr;
    logic s_flag, p_flag, bus_free, irq_flag, irq;

    int n_vec  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    bus_cond_watch dut (
        .clk(clk), .rst(rst), .mod_en(mod_en), .irq_en(irq_en),
        .scl_s(scl_s), .sda_s(sda_s), .byte_done(byte_done), .flag_clr(flag_clr),
        .s_flag(s_flag), .p_flag(p_flag), .bus_free(bus_free),
        .irq_flag(irq_flag), .irq(irq)
    );

    // inputs {en, ien, scl, sda, bd, clr} _ expected {s, p, free, flag, irq}
    localparam int NV = 21;
    localparam logic [10:0] VEC [NV] = '{
        11'b111100_00100, // idle
        11'b111000_10011, // R2 start
        11'b110001_10000, // clear, clock falls
        11'b110100_10000, // R4 data rises with clock low
        11'b111100_10000, // R11 clock rises, data steady
        11'b110110_10011, // R6 byte done
        11'b100100_10010, // R7 irq masked
        11'b100101_10000, // R6 clear
        11'b111100_10000, // clock rises
        11'b111000_10011, // R8 repeated start
        11'b110001_10000, // clear
        11'b111000_10000, // R11 clock rises, data low
        11'b111101_01111, // R3 stop with clear, R10 set wins
        11'b111101_01100, // clear, R5 free after stop
        11'b101000_10010, // R7 start while masked
        11'b111001_10000, // clear
        11'b011000_00100, // R9 disable clears flags
        11'b011100_00100, // R9 stop ignored
        11'b011010_00100, // R9 start and byte ignored
        11'b111000_00100, // R9 enable on steady lines
        11'b111100_01111  // R3 stop
    };

    task automatic check(input string req, input logic [4:0] got, input logic [4:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got s,p,free,flag,irq=%b expected %b", req, got, exp);
        end
    endtask

    task automatic drive(input logic [5:0] v);
        {mod_en, irq_en, scl_s, sda_s, byte_done, flag_clr} = v;
    endtask

    initial begin
        #150000;
        n_fail++;
        $display("FAIL watchdog: got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        drive(6'b111100);
        repeat (3) @(posedge clk);
        #1 check("R1 reset", {s_flag, p_flag, bus_free, irq_flag, irq}, 5'b00100);
        @(negedge clk) rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk) drive(VEC[i][10:5]);
            @(posedge clk);
            #1 check($sformatf("vector %0d", i), {s_flag, p_flag, bus_free, irq_flag, irq}, VEC[i][4:0]);
        end

        // R1: reset while busy with the flag set
        @(negedge clk) drive(6'b111000);   // start
        @(posedge clk);
        #1 check("R2 start before reset", {s_flag, p_flag, bus_free, irq_flag, irq}, 5'b10011);
        @(negedge clk) rst = 1'b1;
        @(posedge clk);
        #1 check("R1 reset when busy", {s_flag, p_flag, bus_free, irq_flag, irq}, 5'b00100);
        @(negedge clk) begin rst = 1'b0; drive(6'b111000); end
        @(posedge clk);
        // reset restores idle-high history, so data low now looks like a fall
        #1 check("R2 start after reset", {s_flag, p_flag, bus_free, irq_flag, irq}, 5'b10011);

        // R4: several data toggles with the clock low, after a clear
        @(negedge clk) drive(6'b110001);
        @(posedge clk);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk) drive({4'b1101 ^ {3'b000, k[0]}, 2'b00});
            @(posedge clk);
            #1 check("R4 toggle clock low", {s_flag, p_flag, bus_free, irq_flag, irq}, 5'b10000);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule